// File: doc/BRIEF.md
# Reset-to-Lock Sequencer

This block orders the start-up of a multi-output clock distribution device. A device reset pin (active low) brings everything back to a quiet state. When it is released, the block asks the configuration loader for a fresh load. Once the loader reports that it is done, the block enables the frequency-multiplier loop. When that loop reports lock, it enables the per-channel deskew stages. It raises `lock` only when the loop is locked and every deskew channel reports that it has settled.

A watchdog counter measures how long the block waits for lock after configuration. If the programmed window runs out, it raises a time-out flag. That flag stays set until the next configuration load. The sequence itself keeps running while the flag is set.

The device reset pin first passes through a synchronizer and then a minimum-width filter. A glitch shorter than the programmed number of cycles therefore leaves a running device untouched. A configuration bit for bypass mode is sampled when loading finishes. In bypass mode the loop and deskew enables stay off and `lock` follows straight from configuration.

Top module: `lock_seq`

## Requirements
- R1: While `arst_n` is low, all outputs (`load_req`, `pll_en`, `dsk_en`, `lock`, `lock_timeout`) are 0.
- R2: After reset, `load_req` is 1 until `cfg_done` is seen. `pll_en` then rises with `dsk_en` still 0. `dsk_en` rises only after `pll_locked` is seen. No enable appears before its predecessor.
- R3: `lock` rises only when `pll_locked` is 1 and all NUM_CH bits of `dsk_settled` are 1. Any single channel at 0 keeps `lock` at 0 while `dsk_en` stays 1.
- R4: A `dev_rst_n` low pulse of at least MIN_RST_CYC cycles drives all outputs to 0 while it is held. After release, `load_req` returns and `lock` stays 0 until a new `cfg_done`, even with all status inputs high. The time-out flag is clear while loading.
- R5: `lock_timeout` rises exactly TMO_CYC cycles after the block enters the loop-wait state without reaching lock. It stays set through later lock and loss events until the next configuration load.
- R6: A `dev_rst_n` low pulse shorter than MIN_RST_CYC cycles has no effect: `lock` stays 1 throughout and after it.
- R7: After lock, a drop of `pll_locked` clears `lock` and `dsk_en` on the next cycle while `pll_en` stays 1. A drop of any `dsk_settled` bit clears only `lock`. Restoring the status re-acquires `lock`.
- R8: If `test_mode` is 1 when `cfg_done` arrives, `lock` goes to 1 on the next cycle with `pll_en` and `dsk_en` at 0. It then ignores `pll_locked` and `dsk_settled`, and no time-out is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous block reset, active low |
| dev_rst_n | input | 1 | Device reset pin, active low, asynchronous to `clk`, width-filtered |
| test_mode | input | 1 | Bypass configuration bit, sampled with `cfg_done` |
| cfg_done | input | 1 | Loader reports configuration complete |
| pll_locked | input | 1 | Multiplier loop lock status |
| dsk_settled | input | NUM_CH | Per-channel deskew settled status |
| load_req | output | 1 | Request to the loader to fetch configuration |
| pll_en | output | 1 | Enable for the multiplier loop |
| dsk_en | output | 1 | Enable for all deskew channels |
| lock | output | 1 | Device locked, active high |
| lock_timeout | output | 1 | Lock not reached within TMO_CYC cycles |

## Verification
The sequencer state is visible at the ports on the cycle after each transition. A state that is wrong appears within one clock as a wrong combination of the four enable-style outputs. Examples are a `dsk_en` without `pll_en`, or a `lock` that appears while a channel is unsettled.

Defects in the reset filter and the time-out counter show up at their exact boundaries. A filter that is off by one either drops lock on a pulse one cycle too short or misses a pulse of exactly the minimum width. A counter that is off by one moves the time-out flag by one cycle away from TMO_CYC. The bench sweeps each deskew channel individually and probes both sides of each boundary.

// File: rtl/lock_seq_pkg.sv
package lock_seq_pkg;

  typedef enum logic [2:0] {
    ST_HOLD = 3'd0,
    ST_LOAD = 3'd1,
    ST_PLL  = 3'd2,
    ST_DSK  = 3'd3,
    ST_LOCK = 3'd4,
    ST_TEST = 3'd5
  } seq_state_e;

endpackage

// File: rtl/lock_seq_rstfilt.sv
// Synchronizes the device reset pin and qualifies it by minimum low width.
module lock_seq_rstfilt #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 5
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_n,
  output logic pin_low_o,
  output logic hold_o
);

  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_LOW);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          low_cnt_q;
  logic [CW-1:0]          low_cnt_d;
  logic                   pin_low;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q[0] <= 1'b0;
        else         sync_q[0] <= pin_n;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign pin_low = ~sync_q[SYNC_STAGES-1];

  always_comb begin
    if (!pin_low)                 low_cnt_d = '0;
    else if (low_cnt_q == CNT_MAX) low_cnt_d = low_cnt_q;
    else                          low_cnt_d = low_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) low_cnt_q <= '0;
    else         low_cnt_q <= low_cnt_d;
  end

  assign pin_low_o = pin_low;
  assign hold_o    = (low_cnt_q == CNT_MAX);

  // R6: a qualified reset needs the synchronized pin to have been low last cycle
  p_hold_needs_low_r6: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(hold_o) |-> $past(pin_low));

endmodule

// File: rtl/lock_seq_tmo.sv
// Counts cycles spent waiting for lock and raises a sticky flag at the limit.
module lock_seq_tmo #(
  parameter int LIMIT = 1100000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic run,
  input  logic clr_all,
  output logic flag_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          cnt_en;

  assign cnt_en = run & ~flag_q;

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (clr_all) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else if (!run) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R5: the flag only appears while waiting, and only a reload clears it
  p_flag_rise_waiting_r5: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(flag_o) |-> $past(run));
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (flag_o && !clr_all) |=> flag_o);

endmodule

// File: rtl/lock_seq_fsm.sv
// Start-up order: hold -> load -> loop -> deskew -> lock (or bypass).
module lock_seq_fsm
  import lock_seq_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       hold,
  input  logic       pin_low,
  input  logic       cfg_done,
  input  logic       test_mode,
  input  logic       pll_locked,
  input  logic       all_settled,
  output seq_state_e state_o
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (hold) begin
      state_d = ST_HOLD;
    end else begin
      unique case (state_q)
        ST_HOLD: if (!pin_low) state_d = ST_LOAD;
        ST_LOAD: if (cfg_done) state_d = test_mode ? ST_TEST : ST_PLL;
        ST_PLL:  if (pll_locked) state_d = ST_DSK;
        ST_DSK: begin
          if (!pll_locked)      state_d = ST_PLL;
          else if (all_settled) state_d = ST_LOCK;
        end
        ST_LOCK: begin
          if (!pll_locked)       state_d = ST_PLL;
          else if (!all_settled) state_d = ST_DSK;
        end
        ST_TEST: state_d = ST_TEST;
        default: state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state_q <= ST_HOLD;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R3: lock is entered only from a cycle where loop and all channels were good
  p_lock_entry_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_LOCK && $past(state_q) != ST_LOCK) |-> $past(pll_locked && all_settled));
  // R7: losing the loop while locked falls back to loop wait
  p_loop_loss_r7: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_LOCK && !pll_locked && !hold) |=> state_q == ST_PLL);
  // R8: bypass persists until a qualified reset
  p_test_stays_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_TEST && !hold) |=> state_q == ST_TEST);

endmodule

// File: rtl/lock_seq.sv
module lock_seq
  import lock_seq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RST_CYC = 5,
  parameter int TMO_CYC     = 1100000
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              dev_rst_n,
  input  logic              test_mode,
  input  logic              cfg_done,
  input  logic              pll_locked,
  input  logic [NUM_CH-1:0] dsk_settled,
  output logic              load_req,
  output logic              pll_en,
  output logic              dsk_en,
  output logic              lock,
  output logic              lock_timeout
);

  logic       hold;
  logic       pin_low;
  logic       all_settled;
  logic       wait_run;
  logic       tmo_clr;
  seq_state_e state;

  assign all_settled = &dsk_settled;

  lock_seq_rstfilt #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_LOW    (MIN_RST_CYC)
  ) u_rstfilt (
    .clk      (clk),
    .arst_n   (arst_n),
    .pin_n    (dev_rst_n),
    .pin_low_o(pin_low),
    .hold_o   (hold)
  );

  lock_seq_fsm u_fsm (
    .clk        (clk),
    .arst_n     (arst_n),
    .hold       (hold),
    .pin_low    (pin_low),
    .cfg_done   (cfg_done),
    .test_mode  (test_mode),
    .pll_locked (pll_locked),
    .all_settled(all_settled),
    .state_o    (state)
  );

  assign wait_run = (state == ST_PLL) || (state == ST_DSK);
  assign tmo_clr  = (state == ST_HOLD) || (state == ST_LOAD);

  lock_seq_tmo #(
    .LIMIT(TMO_CYC)
  ) u_tmo (
    .clk    (clk),
    .arst_n (arst_n),
    .run    (wait_run),
    .clr_all(tmo_clr),
    .flag_o (lock_timeout)
  );

  assign load_req = (state == ST_LOAD);
  assign pll_en   = (state == ST_PLL) || (state == ST_DSK) || (state == ST_LOCK);
  assign dsk_en   = (state == ST_DSK) || (state == ST_LOCK);
  assign lock     = (state == ST_LOCK) || (state == ST_TEST);

  // R2: deskew is enabled only after the loop reported lock
  p_dsk_after_loop_r2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(dsk_en) |-> $past(pll_locked));
  // R2: the load request ends only on loader completion or a qualified reset
  p_load_exit_r2: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(load_req) |-> $past(cfg_done || hold));
  // R4: loading always starts with a clear time-out flag
  p_load_clean_r4: assert property (@(posedge clk) disable iff (!arst_n)
    load_req |-> !lock_timeout);

endmodule

// File: tb/lock_seq_test.sv
module lock_seq_test;

  localparam int NCH  = 8;
  localparam int MINR = 4;
  localparam int TMO  = 40;

  logic           clk = 1'b0;
  logic           arst_n;
  logic           dev_rst_n;
  logic           test_mode;
  logic           cfg_done;
  logic           pll_locked;
  logic [NCH-1:0] dsk_settled;
  logic           load_req, pll_en, dsk_en, lock, lock_timeout;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  lock_seq #(
    .NUM_CH(NCH), .SYNC_STAGES(2), .MIN_RST_CYC(MINR), .TMO_CYC(TMO)
  ) uut (
    .clk(clk), .arst_n(arst_n), .dev_rst_n(dev_rst_n), .test_mode(test_mode),
    .cfg_done(cfg_done), .pll_locked(pll_locked), .dsk_settled(dsk_settled),
    .load_req(load_req), .pll_en(pll_en), .dsk_en(dsk_en), .lock(lock),
    .lock_timeout(lock_timeout)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // outputs packed as {load_req, pll_en, dsk_en, lock}
  function automatic logic [3:0] outs();
    return {load_req, pll_en, dsk_en, lock};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; dev_rst_n = 1'b1; test_mode = 1'b0; cfg_done = 1'b0;
    pll_locked = 1'b0; dsk_settled = '0;
    @(negedge clk);
    tick(3);
    // R1: everything quiet under block reset
    chk("R1 outputs in reset", {28'd0, outs()}, 32'd0);
    chk("R1 timeout in reset", lock_timeout, 0);
    arst_n = 1'b1;
    tick(4);
    // R2: loading requested, nothing else
    chk("R2 load requested", {28'd0, outs()}, 32'b1000);
    tick(5);
    chk("R2 still loading", {28'd0, outs()}, 32'b1000);
    cfg_done = 1'b1;
    tick(1);
    cfg_done = 1'b0;
    chk("R2 loop enabled after load", {28'd0, outs()}, 32'b0100);
    // R5: exact time-out boundary
    tick(TMO - 1);
    chk("R5 no timeout one cycle early", lock_timeout, 0);
    tick(1);
    chk("R5 timeout at limit", lock_timeout, 1);
    chk("R2 deskew held off without loop lock", dsk_en, 0);
    pll_locked = 1'b1;
    tick(1);
    chk("R2 deskew after loop lock", {28'd0, outs()}, 32'b0110);
    chk("R5 timeout sticky in deskew wait", lock_timeout, 1);
    // R3: each single unsettled channel blocks lock
    for (int c = 0; c < NCH; c++) begin
      dsk_settled = ~(NCH'(1) << c);
      tick(2);
      chk($sformatf("R3 ch%0d missing blocks lock", c), lock, 0);
      chk($sformatf("R3 ch%0d missing keeps deskew", c), dsk_en, 1);
    end
    dsk_settled = '1;
    tick(1);
    chk("R3 lock with all settled", {28'd0, outs()}, 32'b0111);
    chk("R5 timeout sticky after lock", lock_timeout, 1);
    // R7: channel loss and loop loss
    dsk_settled[3] = 1'b0;
    tick(1);
    chk("R7 channel loss drops lock only", {28'd0, outs()}, 32'b0110);
    dsk_settled[3] = 1'b1;
    tick(1);
    chk("R7 channel recovery relocks", lock, 1);
    pll_locked = 1'b0;
    tick(1);
    chk("R7 loop loss back to loop wait", {28'd0, outs()}, 32'b0100);
    pll_locked = 1'b1;
    tick(1);
    chk("R7 deskew re-enabled", {28'd0, outs()}, 32'b0110);
    tick(1);
    chk("R7 relocked", lock, 1);
    // R6: pulse one cycle short of minimum is ignored
    begin
      int drops = 0;
      dev_rst_n = 1'b0;
      for (int i = 0; i < MINR - 1; i++) begin
        tick(1);
        if (!lock) drops++;
      end
      dev_rst_n = 1'b1;
      for (int i = 0; i < 10; i++) begin
        tick(1);
        if (!lock) drops++;
      end
      chk("R6 short pulse lock drops", drops, 0);
      chk("R6 short pulse outputs", {28'd0, outs()}, 32'b0111);
    end
    // R4: pulse of exactly the minimum width takes effect
    dev_rst_n = 1'b0;
    tick(MINR);
    dev_rst_n = 1'b1;
    tick(12);
    chk("R4 min pulse reloads", {28'd0, outs()}, 32'b1000);
    chk("R4 timeout cleared on reload", lock_timeout, 0);
    tick(5);
    chk("R4 no lock without new config", {28'd0, outs()}, 32'b1000);
    // R4: long reset holds everything low
    dev_rst_n = 1'b0;
    tick(20);
    chk("R4 held reset outputs", {28'd0, outs()}, 32'd0);
    dev_rst_n = 1'b1;
    tick(8);
    chk("R4 release requests load", {28'd0, outs()}, 32'b1000);
    // R8: bypass mode
    test_mode = 1'b1; pll_locked = 1'b0; dsk_settled = '0;
    cfg_done = 1'b1;
    tick(1);
    cfg_done = 1'b0; test_mode = 1'b0;
    chk("R8 bypass locks at once", {28'd0, outs()}, 32'b0001);
    tick(TMO + 10);
    chk("R8 bypass holds lock", {28'd0, outs()}, 32'b0001);
    chk("R8 bypass no timeout", lock_timeout, 0);
    dev_rst_n = 1'b0;
    tick(MINR + 6);
    chk("R4 reset leaves bypass", {28'd0, outs()}, 32'd0);
    dev_rst_n = 1'b1;
    tick(8);
    chk("R4 reload after bypass", load_req, 1);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule